// File: doc/BRIEF.md
# Crosspoint Switch Matrix Write Sequencer

This block sits on the host side of a 16-row by 8-column analog crosspoint switch array whose control memory is a set of transparent latches. It takes one request at a time over a valid/ready handshake. A request either sets one crosspoint on or off, or clears the whole matrix.

For a single crosspoint the sequencer raises chip select. It then presents the row address code, the column and the data bit, and pulses the strobe. It keeps chip select, address and data steady for a hold phase after the strobe falls. A clear request drives the array's reset line high for a set number of cycles instead.

The array numbers its row address codes in a permuted order, so the block maps each physical row number to the code the array decodes. Every phase length is a parameter counted in system clock cycles. This lets the integrator meet the array's nanosecond setup, strobe-width, hold and reset-width minimums at any clock rate.

Top module: `xpt_write_seq`

## Requirements
- R1: While rst_n is low, and afterwards until a request is accepted, sw_strobe, sw_rst and sw_cs are 0 and req_ready is 1. Asserting rst_n low in the middle of a transaction forces all three controls low at once.
- R2: A write request accepted at clock edge E gives the following outputs. sw_cs is 1 for SETUP_CYC + PULSE_CYC + HOLD_CYC cycles after E. sw_strobe is 1 for exactly the PULSE_CYC cycles that start SETUP_CYC cycles after E. sw_strobe rises only after sw_cs has been high for at least one cycle, and sw_cs stays high for HOLD_CYC cycles after sw_strobe falls.
- R3: sw_addr_x, sw_addr_y and sw_data do not change in any cycle in which sw_cs stays high.
- R4: sw_addr_x carries the row code for req_row. Rows 0-5, 14 and 15 map to their own number, rows 6-11 map to codes 8-13, and rows 12 and 13 map to codes 6 and 7.
- R5: sw_addr_y equals req_col of the accepted request.
- R6: sw_data equals req_on of the accepted write, where 1 turns the crosspoint on and 0 turns it off. It is constant for the whole time sw_strobe is high.
- R7: A request with req_clear = 1 drives sw_rst high for CLR_CYC cycles after acceptance, and never asserts sw_strobe or sw_cs.
- R8: req_ready is 0 from the accepting edge until the hold phase or reset pulse ends. A request presented while req_ready is 0 has no effect on the outputs.
- R9: Whenever sw_strobe is 1, sw_cs is 1 and sw_rst is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_clear | input | 1 | 1 = clear entire matrix, 0 = single crosspoint write |
| req_row | input | 4 | Physical row 0-15 |
| req_col | input | 3 | Column 0-7 |
| req_on | input | 1 | Crosspoint value: 1 on, 0 off |
| sw_cs | output | 1 | Chip select to the array |
| sw_strobe | output | 1 | Latch strobe to the array |
| sw_rst | output | 1 | Master reset to the array |
| sw_addr_x | output | 4 | Row address code |
| sw_addr_y | output | 3 | Column address |
| sw_data | output | 1 | Data bit to the latches |

## Verification
The hardest case to reach from the ports is a second request that competes with a transaction already in flight. The bench holds req_valid high with a different row, column and value for the whole busy window. It then drops req_valid in the final hold cycle and confirms two things: that every address and data output kept the first request's values, and that no second chip-select pulse follows. A second hard case is an asynchronous reset landing while the strobe is high. The bench pulls rst_n low in the middle of the pulse and samples the controls one time unit later, before any clock edge.

// File: rtl/xpt_seq_pkg.sv
package xpt_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_CLEAR
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xpt_row_map.sv
module xpt_row_map (
  input  logic [3:0] row,
  output logic [3:0] code
);

  // Physical rows 6-11 sit two codes higher; rows 12-13 fold into codes 6-7.
  always_comb begin
    code = row;
    if (row >= 4'd6 && row <= 4'd11) begin
      code = row + 4'd2;
    end else if (row == 4'd12 || row == 4'd13) begin
      code = row - 4'd6;
    end
  end

endmodule

// File: rtl/xpt_phase_timer.sv
module xpt_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == (len - CNT_W'(1)));

endmodule

// File: rtl/xpt_write_seq.sv
module xpt_write_seq
  import xpt_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned CLR_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_clear,
  input  logic [3:0] req_row,
  input  logic [2:0] req_col,
  input  logic       req_on,
  output logic       sw_cs,
  output logic       sw_strobe,
  output logic       sw_rst,
  output logic [3:0] sw_addr_x,
  output logic [2:0] sw_addr_y,
  output logic       sw_data
);

  localparam int unsigned MAX_LEN = max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, CLR_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] phase_len;
  logic             phase_last;
  logic             restart;
  logic             accept;
  logic             load_wr;
  logic [3:0]       row_code;

  logic             cs_q, stb_q, rst_q;
  logic [3:0]       ax_q;
  logic [2:0]       ay_q;
  logic             data_q;

  xpt_row_map i_row_map (
    .row  (req_row),
    .code (row_code)
  );

  always_comb begin
    unique case (state_q)
      ST_SETUP: phase_len = CNT_W'(SETUP_CYC);
      ST_PULSE: phase_len = CNT_W'(PULSE_CYC);
      ST_HOLD:  phase_len = CNT_W'(HOLD_CYC);
      ST_CLEAR: phase_len = CNT_W'(CLR_CYC);
      default:  phase_len = CNT_W'(1);
    endcase
  end

  xpt_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cnt_en  (state_q != ST_IDLE),
    .len     (phase_len),
    .last    (phase_last)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign load_wr   = accept && !req_clear;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = req_clear ? ST_CLEAR : ST_SETUP;
      ST_SETUP: if (phase_last) state_d = ST_PULSE;
      ST_PULSE: if (phase_last) state_d = ST_HOLD;
      ST_HOLD:  if (phase_last) state_d = ST_IDLE;
      ST_CLEAR: if (phase_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign restart = (state_d != state_q);

  // State and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b0;
      stb_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= (state_d == ST_SETUP) || (state_d == ST_PULSE) || (state_d == ST_HOLD);
      stb_q   <= (state_d == ST_PULSE);
      rst_q   <= (state_d == ST_CLEAR);
    end
  end

  // Address and data holding registers, loaded only on an accepted write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ax_q   <= '0;
      ay_q   <= '0;
      data_q <= 1'b0;
    end else if (load_wr) begin
      ax_q   <= row_code;
      ay_q   <= req_col;
      data_q <= req_on;
    end
  end

  assign sw_cs     = cs_q;
  assign sw_strobe = stb_q;
  assign sw_rst    = rst_q;
  assign sw_addr_x = ax_q;
  assign sw_addr_y = ay_q;
  assign sw_data   = data_q;

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_strobe |-> (sw_cs && !sw_rst));

  // R2
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_strobe) |-> $past(sw_cs));

  // R2
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_strobe) |-> sw_cs);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cs && $past(sw_cs)) |-> ($stable(sw_addr_x) && $stable(sw_addr_y) && $stable(sw_data)));

  // R7
  clear_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |-> !sw_cs);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cs || sw_rst) |-> !req_ready);

endmodule

// File: tb/test_xpt_write_seq.sv
module test_xpt_write_seq;

  localparam int S   = 2;
  localparam int P   = 3;
  localparam int H   = 1;
  localparam int C   = 4;
  localparam int TOT = S + P + H;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic       req_clear;
  logic [3:0] req_row;
  logic [2:0] req_col;
  logic       req_on;
  logic       sw_cs, sw_strobe, sw_rst;
  logic [3:0] sw_addr_x;
  logic [2:0] sw_addr_y;
  logic       sw_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  xpt_write_seq #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .CLR_CYC(C)) i_xpt_write_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_clear(req_clear), .req_row(req_row), .req_col(req_col), .req_on(req_on),
    .sw_cs(sw_cs), .sw_strobe(sw_strobe), .sw_rst(sw_rst),
    .sw_addr_x(sw_addr_x), .sw_addr_y(sw_addr_y), .sw_data(sw_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Code-to-row table as the array decodes it; inverted by search below.
  function automatic int code_to_row(input int c);
    if (c < 6)       return c;
    else if (c == 6) return 12;
    else if (c == 7) return 13;
    else if (c < 14) return c - 2;
    else             return c;
  endfunction

  function automatic int exp_code(input int row);
    for (int c = 0; c < 16; c++) if (code_to_row(c) == row) return c;
    return -1;
  endfunction

  task automatic check_idle(input string req);
    chk(sw_cs == 1'b0, req, sw_cs, 0);
    chk(sw_strobe == 1'b0, req, sw_strobe, 0);
    chk(sw_rst == 1'b0, req, sw_rst, 0);
    chk(req_ready == 1'b1, req, req_ready, 1);
  endtask

  // Write one crosspoint; optionally hold a competing request during the busy window.
  task automatic do_write(input int row, input int col, input bit on, input bit intrude);
    int code;
    code = exp_code(row);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready before write", req_ready, 1);
    req_valid = 1'b1; req_clear = 1'b0;
    req_row = 4'(row); req_col = 3'(col); req_on = on;
    for (int k = 1; k <= TOT + 1; k++) begin
      @(negedge clk);
      if (k == 1 && !intrude) req_valid = 1'b0;
      chk(sw_cs == (k <= TOT), "R2 cs window", sw_cs, (k <= TOT));
      chk(sw_strobe == (k > S && k <= S + P), "R2 strobe window", sw_strobe, (k > S && k <= S + P));
      chk(sw_rst == 1'b0, "R9 no reset during write", sw_rst, 0);
      chk(req_ready == (k > TOT), "R8 ready during write", req_ready, (k > TOT));
      if (k <= TOT) begin
        chk(sw_addr_x == 4'(code), "R4 row code", sw_addr_x, code);
        chk(sw_addr_y == 3'(col), "R5 column", sw_addr_y, col);
        chk(sw_data == on, "R6 data", sw_data, on);
        chk(sw_addr_x == 4'(code) && sw_addr_y == 3'(col) && sw_data == on,
            "R3 held through transaction", {sw_addr_x, sw_addr_y, sw_data}, {code[3:0], col[2:0], on});
      end
      if (k == 1 && intrude) begin
        req_row = ~req_row; req_col = ~req_col; req_on = ~on;
      end
      if (k == TOT && intrude) req_valid = 1'b0;
    end
    if (intrude) begin
      @(negedge clk);
      chk(sw_cs == 1'b0, "R8 busy request ignored", sw_cs, 0);
      chk(sw_addr_x == 4'(code), "R8 busy request left row", sw_addr_x, code);
      chk(sw_data == on, "R8 busy request left data", sw_data, on);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    req_valid = 1'b1; req_clear = 1'b1;
    for (int k = 1; k <= C + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin req_valid = 1'b0; req_clear = 1'b0; end
      chk(sw_rst == (k <= C), "R7 reset pulse", sw_rst, (k <= C));
      chk(sw_strobe == 1'b0, "R7 no strobe", sw_strobe, 0);
      chk(sw_cs == 1'b0, "R7 no cs", sw_cs, 0);
      chk(req_ready == (k > C), "R8 ready during clear", req_ready, (k > C));
    end
  endtask

  task automatic reset_mid_strobe();
    @(negedge clk);
    req_valid = 1'b1; req_clear = 1'b0; req_row = 4'd3; req_col = 3'd2; req_on = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (S + 1) @(negedge clk);
    chk(sw_strobe == 1'b1, "R2 strobe before reset", sw_strobe, 1);
    #1 rst_n = 1'b0;
    #1;
    check_idle("R1 async reset mid strobe");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_clear = 1'b0;
    req_row = '0; req_col = '0; req_on = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 after reset");

    for (int r = 0; r < 16; r++) do_write(r, r % 8, r[0], 1'b0);
    do_write(13, 7, 1'b1, 1'b0);
    do_write(6, 0, 1'b0, 1'b0);
    do_clear();
    do_write(9, 5, 1'b1, 1'b1);
    do_clear();
    reset_mid_strobe();
    do_write(12, 3, 1'b1, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule